// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR-type SDRAM and takes the memory from power-on to a usable state. After reset it holds the clock-enable pin low for a programmable settling time. It then raises clock enable with a NOP and issues a fixed chain of commands: precharge-all, an extended mode write that turns the DLL on, a mode write that resets the DLL, a second precharge-all, a programmable number of auto-refreshes, and a final mode write that carries the operating latency and burst settings with the DLL-reset bit cleared.

Down counters insert the required gap after each command. The gaps are the row-precharge time, the refresh cycle time and a fixed four-cycle mode-write time, all given as parameters in clock cycles. A separate counter starts when the DLL is enabled and must run out before the ready flag may rise, so the DLL lock time overlaps the later steps. A parameter swaps the DLL-reset write and the second precharge. A synchronous restart input reruns the whole sequence from the clock-enable-low state.

Command pins use the usual active-low encoding {cs_n, ras_n, cas_n, we_n}: NOP = 0111, precharge = 0010, auto-refresh = 0001, mode write = 0000. Every pin is registered.

Top module: `sdram_init_seq`

## Requirements
- R1: From the reset edge, and from any edge at which restart is sampled high, cke stays 0 with a NOP on the pins for STABLE_CYC more cycles. On the next cycle cke rises together with a NOP, and it stays high until the next reset or restart.
- R2: A precharge-all is code 0010 with address bit 8 high, all other address bits 0 and bank pins 00. The first one follows the cke-rising cycle immediately, and the next command comes exactly TRP_CYC cycles after it.
- R3: The DLL-enable write is code 0000 with bank pins 01 and an all-zero address (bit 0 = 0 enables the DLL, bits 1 and 6 = 0 select full drive). It comes TRP_CYC cycles after the first precharge, and the next command comes exactly TMRD_CYC (4) cycles after it.
- R4: The DLL-reset write is code 0000 with bank pins 00 and an address equal to OP_MODE bits 6:0 with bit 8 set and bits 7 and 11:9 clear. The next command comes exactly TMRD_CYC cycles after it.
- R5: With SWAP_ORDER = 0 the order is DLL-enable write, DLL-reset write, second precharge. With SWAP_ORDER = 1 the second precharge comes before the DLL-reset write. Each keeps its own gap in both orders.
- R6: NUM_REF (at least 2) auto-refreshes follow, each code 0001 with zero bank and address pins, and each followed by exactly TRFC_CYC cycles before the next command.
- R7: The last command is a mode write with bank pins 00, address bits 6:0 equal to OP_MODE bits 6:0, and bits 11:7 clear, so the DLL-reset bit 8 is low.
- R8: Ready rises exactly at max(final write + TMRD_CYC, DLL-enable write + DLL_LOCK_CYC) and then holds with cke high and NOP on the pins.
- R9: Every cycle that carries none of the commands above drives a NOP with zero bank and address pins.
- R10: Restart is synchronous. At the edge that samples it, cke and ready go low, and the complete sequence is then repeated with the same cycle spacing as after reset.
- R11: Ready is 0 from reset or restart until the cycle given in R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| restart_i | input | 1 | Synchronous request to rerun the sequence |
| cke_o | output | 1 | Memory clock enable |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | BA_W | Bank pins |
| addr_o | output | ADDR_W | Address pins |
| init_done_o | output | 1 | Sequence complete and DLL locked |

## Verification
Every pin is one register away from the sequencer state. The whole pin set is therefore a pure function of the number of edges since the last reset or restart edge: cke rises at count STABLE_CYC+1, the first precharge-all comes at STABLE_CYC+2, and each later command follows its predecessor by exactly its gap. The bench recomputes that schedule from the parameters and compares all pins once per cycle, half a period after each edge. This makes an early, late or misordered command a mismatch in a definite cycle. Restarts are sampled on the same edge count, so the restarted sequence is checked against the same schedule.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [3:0] {
    ST_CKE_LOW,
    ST_WAKE,
    ST_PRE1,
    ST_EMRS,
    ST_DLLRST,
    ST_PRE2,
    ST_REF,
    ST_MODE,
    ST_GAP,
    ST_READY
  } seq_state_t;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_NOP  = 4'b0111;
  localparam logic [3:0] CMD_PRE  = 4'b0010;
  localparam logic [3:0] CMD_REF  = 4'b0001;
  localparam logic [3:0] CMD_MODE = 4'b0000;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/init_delay_ctr.sv
module init_delay_ctr #(
  parameter int W = 8,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr)        cnt_q <= INIT;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/init_pin_reg.sv
module init_pin_reg
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BA_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              cke_d,
  input  logic [3:0]        cmd_d,
  input  logic [BA_W-1:0]   ba_d,
  input  logic [ADDR_W-1:0] addr_d,
  input  logic              done_d,
  output logic              cke_q,
  output logic [3:0]        cmd_q,
  output logic [BA_W-1:0]   ba_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              done_q
);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cke_q  <= 1'b0;
      cmd_q  <= CMD_NOP;
      ba_q   <= '0;
      addr_q <= '0;
      done_q <= 1'b0;
    end else begin
      cke_q  <= cke_d;
      cmd_q  <= cmd_d;
      ba_q   <= ba_d;
      addr_q <= addr_d;
      done_q <= done_d;
    end
  end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int STABLE_CYC   = 50000,
  parameter int TRP_CYC      = 6,
  parameter int TRFC_CYC     = 20,
  parameter int TMRD_CYC     = 4,
  parameter int DLL_LOCK_CYC = 200,
  parameter int NUM_REF      = 2,
  parameter bit SWAP_ORDER   = 1'b0,
  parameter int ADDR_W       = 12,
  parameter int BA_W         = 2,
  parameter int PALL_BIT     = 8,
  parameter int MODE_FLD_W   = 7,
  parameter logic [ADDR_W-1:0] OP_MODE = 12'h052
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart_i,
  output logic              cke_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              init_done_o
);

  localparam int WAIT_MAX = max2(max2(STABLE_CYC, TRP_CYC), max2(TRFC_CYC, TMRD_CYC));
  localparam int WW = $clog2(WAIT_MAX + 1);
  localparam int LW = $clog2(DLL_LOCK_CYC + 1);
  localparam int RW = $clog2(NUM_REF + 1);

  localparam logic [WW-1:0] GAP_RP   = WW'(TRP_CYC - 2);
  localparam logic [WW-1:0] GAP_RFC  = WW'(TRFC_CYC - 2);
  localparam logic [WW-1:0] GAP_MRD  = WW'(TMRD_CYC - 2);
  localparam logic [WW-1:0] WAIT_INI = WW'(STABLE_CYC - 1);
  localparam logic [LW-1:0] LOCK_INI = LW'(DLL_LOCK_CYC - 1);
  localparam logic [RW-1:0] REF_LAST = RW'(NUM_REF - 1);

  localparam logic [ADDR_W-1:0] MODE_MASK = ADDR_W'((1 << MODE_FLD_W) - 1);
  localparam logic [ADDR_W-1:0] PALL_ADDR = ADDR_W'(1) << PALL_BIT;
  localparam logic [ADDR_W-1:0] MODE_WORD = OP_MODE & MODE_MASK;
  localparam logic [ADDR_W-1:0] DLLRST_WORD = MODE_WORD | PALL_ADDR;
  localparam logic [BA_W-1:0]   BA_EXT = BA_W'(1);

  seq_state_t state_q, state_d, ret_q, ret_d;
  seq_state_t after_emrs, after_dll, after_pre2;
  logic [RW-1:0] ref_q, ref_d;
  logic          wait_ld, wait_zero, lock_zero;
  logic [WW-1:0] wait_val;

  // Order variant for the DLL-reset write and the second precharge
  generate
    if (SWAP_ORDER) begin : g_swap
      assign after_emrs = ST_PRE2;
      assign after_pre2 = ST_DLLRST;
      assign after_dll  = ST_REF;
    end else begin : g_plain
      assign after_emrs = ST_DLLRST;
      assign after_dll  = ST_PRE2;
      assign after_pre2 = ST_REF;
    end
  endgenerate

  init_delay_ctr #(.W(WW), .INIT(WAIT_INI)) u_wait (
    .clk(clk), .rst(rst), .clr(restart_i),
    .load(wait_ld), .load_val(wait_val), .zero(wait_zero)
  );

  init_delay_ctr #(.W(LW), .INIT(LOCK_INI)) u_lock (
    .clk(clk), .rst(rst), .clr(restart_i),
    .load(state_q == ST_EMRS), .load_val(LOCK_INI), .zero(lock_zero)
  );

  always_comb begin
    state_d  = state_q;
    ret_d    = ret_q;
    ref_d    = ref_q;
    wait_ld  = 1'b0;
    wait_val = '0;
    case (state_q)
      ST_CKE_LOW: if (wait_zero) state_d = ST_WAKE;
      ST_WAKE:    state_d = ST_PRE1;
      ST_PRE1: begin
        wait_ld = 1'b1; wait_val = GAP_RP; ret_d = ST_EMRS; state_d = ST_GAP;
      end
      ST_EMRS: begin
        wait_ld = 1'b1; wait_val = GAP_MRD; ret_d = after_emrs; state_d = ST_GAP;
      end
      ST_DLLRST: begin
        wait_ld = 1'b1; wait_val = GAP_MRD; ret_d = after_dll; state_d = ST_GAP;
      end
      ST_PRE2: begin
        wait_ld = 1'b1; wait_val = GAP_RP; ret_d = after_pre2; state_d = ST_GAP;
      end
      ST_REF: begin
        wait_ld = 1'b1; wait_val = GAP_RFC; ref_d = ref_q + 1'b1;
        ret_d   = (ref_q == REF_LAST) ? ST_MODE : ST_REF;
        state_d = ST_GAP;
      end
      ST_MODE: begin
        wait_ld = 1'b1; wait_val = GAP_MRD; ret_d = ST_READY; state_d = ST_GAP;
      end
      ST_GAP:   if (wait_zero) state_d = ret_q;
      ST_READY: state_d = ST_READY;
      default:  state_d = ST_CKE_LOW;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || restart_i) begin
      state_q <= ST_CKE_LOW;
      ret_q   <= ST_CKE_LOW;
      ref_q   <= '0;
    end else begin
      state_q <= state_d;
      ret_q   <= ret_d;
      ref_q   <= ref_d;
    end
  end

  // Pin values for the current state, registered one stage below
  logic              cke_d, done_d;
  logic [3:0]        cmd_d, cmd_q;
  logic [BA_W-1:0]   ba_d;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    cke_d  = (state_q != ST_CKE_LOW);
    done_d = (state_q == ST_READY) && lock_zero;
    cmd_d  = CMD_NOP;
    ba_d   = '0;
    addr_d = '0;
    case (state_q)
      ST_PRE1, ST_PRE2: begin cmd_d = CMD_PRE;  addr_d = PALL_ADDR; end
      ST_EMRS:          begin cmd_d = CMD_MODE; ba_d = BA_EXT; end
      ST_DLLRST:        begin cmd_d = CMD_MODE; addr_d = DLLRST_WORD; end
      ST_REF:           cmd_d = CMD_REF;
      ST_MODE:          begin cmd_d = CMD_MODE; addr_d = MODE_WORD; end
      default:          cmd_d = CMD_NOP;
    endcase
  end

  init_pin_reg #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_pins (
    .clk(clk), .rst(rst), .clr(restart_i),
    .cke_d(cke_d), .cmd_d(cmd_d), .ba_d(ba_d), .addr_d(addr_d), .done_d(done_d),
    .cke_q(cke_o), .cmd_q(cmd_q), .ba_q(ba_o), .addr_q(addr_o), .done_q(init_done_o)
  );

  assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = cmd_q;

  // R1: while clock enable is low only NOP reaches the pins
  a_r1_low_is_nop: assert property (@(posedge clk) disable iff (rst)
    !cke_o |-> (cmd_q == CMD_NOP));
  // R1: clock enable never drops without a restart
  a_r1_cke_holds: assert property (@(posedge clk) disable iff (rst)
    (cke_o && !restart_i) |=> cke_o);
  // R10: restart clears clock enable and ready at the sampling edge
  a_r10_restart_clears: assert property (@(posedge clk) disable iff (rst)
    restart_i |=> (!cke_o && !init_done_o));
  // R8: ready is sticky until restart
  a_r8_done_sticky: assert property (@(posedge clk) disable iff (rst)
    (init_done_o && !restart_i) |=> init_done_o);
  // R8: once ready the pins are quiet
  a_r8_done_quiet: assert property (@(posedge clk) disable iff (rst)
    init_done_o |-> (cke_o && cmd_q == CMD_NOP));
  // R8: ready only after the DLL lock counter has run out
  a_r8_done_locked: assert property (@(posedge clk) disable iff (rst)
    init_done_o |-> lock_zero);
  // R6: refresh count never exceeds the programmed number
  a_r6_ref_bound: assert property (@(posedge clk) disable iff (rst)
    ref_q <= RW'(NUM_REF));

endmodule

// File: tb/sim_sdram_init_seq.sv
module sim_sdram_init_seq;

  localparam int A_ST = 20, A_RP = 3, A_RFC = 7, A_DLL = 60, A_NREF = 2, A_SW = 0;
  localparam logic [11:0] A_OP = 12'h052;
  localparam int B_ST = 10, B_RP = 2, B_RFC = 5, B_DLL = 8, B_NREF = 3, B_SW = 1;
  localparam logic [11:0] B_OP = 12'h0E3;

  logic clk = 1'b0, rst = 1'b1, restart = 1'b0;
  always #2 clk = ~clk;

  logic a_cke, a_cs, a_ras, a_cas, a_we, a_done;
  logic [1:0] a_ba;  logic [11:0] a_addr;
  logic b_cke, b_cs, b_ras, b_cas, b_we, b_done;
  logic [1:0] b_ba;  logic [11:0] b_addr;

  sdram_init_seq #(.STABLE_CYC(A_ST), .TRP_CYC(A_RP), .TRFC_CYC(A_RFC), .TMRD_CYC(4),
    .DLL_LOCK_CYC(A_DLL), .NUM_REF(A_NREF), .SWAP_ORDER(A_SW != 0), .OP_MODE(A_OP)) u0 (
    .clk(clk), .rst(rst), .restart_i(restart), .cke_o(a_cke), .cs_n_o(a_cs),
    .ras_n_o(a_ras), .cas_n_o(a_cas), .we_n_o(a_we), .ba_o(a_ba), .addr_o(a_addr),
    .init_done_o(a_done));

  sdram_init_seq #(.STABLE_CYC(B_ST), .TRP_CYC(B_RP), .TRFC_CYC(B_RFC), .TMRD_CYC(4),
    .DLL_LOCK_CYC(B_DLL), .NUM_REF(B_NREF), .SWAP_ORDER(B_SW != 0), .OP_MODE(B_OP)) u1 (
    .clk(clk), .rst(rst), .restart_i(restart), .cke_o(b_cke), .cs_n_o(b_cs),
    .ras_n_o(b_ras), .cas_n_o(b_cas), .we_n_o(b_we), .ba_o(b_ba), .addr_o(b_addr),
    .init_done_o(b_done));

  int checks = 0, errors = 0;
  bit reported = 0;
  bit clr_seen = 1'b1, via_restart = 1'b0;
  int ca = 0, cb = 0;

  always @(posedge clk) begin
    clr_seen <= rst | restart;
    if (rst) via_restart <= 1'b0;
    else if (restart) via_restart <= 1'b1;
  end

  // Expected command cycles counted from the clearing edge
  function automatic void sched(input int st, rp, rfc, nref, sw,
                                output int p1, e, md, p2, r0, fin);
    p1 = st + 2;
    e  = p1 + rp;
    if (sw != 0) begin p2 = e + 4; md = p2 + rp; r0 = md + 4; end
    else         begin md = e + 4; p2 = md + 4; r0 = p2 + rp; end
    fin = r0 + nref * rfc;
  endfunction

  // 0 NOP, 1 first precharge, 2 DLL enable, 3 DLL reset, 4 refresh, 5 final, 6 second precharge
  function automatic int kind_at(input int c, st, rp, rfc, nref, sw);
    int p1, e, md, p2, r0, fin;
    sched(st, rp, rfc, nref, sw, p1, e, md, p2, r0, fin);
    if (c == p1) return 1;
    if (c == e)  return 2;
    if (c == md) return 3;
    if (c == p2) return 6;
    for (int i = 0; i < nref; i++) if (c == r0 + i * rfc) return 4;
    if (c == fin) return 5;
    return 0;
  endfunction

  function automatic int done_at(input int st, rp, rfc, nref, sw, dll);
    int p1, e, md, p2, r0, fin;
    sched(st, rp, rfc, nref, sw, p1, e, md, p2, r0, fin);
    return (fin + 4 > e + dll) ? fin + 4 : e + dll;
  endfunction

  task automatic check_cycle(input string n, input int c, st, rp, rfc, nref, sw, dll,
                             input logic [11:0] op, input bit rs,
                             input logic cke, input logic [3:0] cmd,
                             input logic [1:0] ba, input logic [11:0] addr, input logic done);
    int k, dc;
    logic ecke, edone;
    logic [3:0] ecmd;
    logic [1:0] eba;
    logic [11:0] eaddr, mw;
    string tag;
    k  = kind_at(c, st, rp, rfc, nref, sw);
    dc = done_at(st, rp, rfc, nref, sw, dll);
    mw = op & 12'h07F;
    ecke = (c > st);
    edone = (c >= dc);
    ecmd = 4'b0111; eba = 2'b00; eaddr = 12'h000;
    case (k)
      1, 6: begin ecmd = 4'b0010; eaddr = 12'h100; end
      2:    begin ecmd = 4'b0000; eba = 2'b01; end
      3:    begin ecmd = 4'b0000; eaddr = mw | 12'h100; end
      4:    ecmd = 4'b0001;
      5:    begin ecmd = 4'b0000; eaddr = mw; end
      default: ;
    endcase
    if (cke !== ecke) tag = (rs && c <= st + 1) ? "R10" : "R1";
    else if (done !== edone) tag = (c < dc) ? "R11" : "R8";
    else case (k)
      1: tag = "R2";
      2: tag = "R3";
      3: tag = "R4";
      4: tag = "R6";
      5: tag = "R7";
      6: tag = "R5";
      default: tag = (c >= dc) ? "R8" : "R9";
    endcase
    checks++;
    if (cke !== ecke || cmd !== ecmd || ba !== eba || addr !== eaddr || done !== edone) begin
      errors++;
      $display("FAIL %s %s c=%0d act cke=%b cmd=%b ba=%b addr=%h done=%b exp cke=%b cmd=%b ba=%b addr=%h done=%b",
               tag, n, c, cke, cmd, ba, addr, done, ecke, ecmd, eba, eaddr, edone);
    end
  endtask

  always @(negedge clk) begin
    if (clr_seen) begin ca = 0; cb = 0; end
    else begin ca++; cb++; end
    if (!reported) begin
      check_cycle("u0", ca, A_ST, A_RP, A_RFC, A_NREF, A_SW, A_DLL, A_OP, via_restart,
                  a_cke, {a_cs, a_ras, a_cas, a_we}, a_ba, a_addr, a_done);
      check_cycle("u1", cb, B_ST, B_RP, B_RFC, B_NREF, B_SW, B_DLL, B_OP, via_restart,
                  b_cke, {b_cs, b_ras, b_cas, b_we}, b_ba, b_addr, b_done);
    end
  end

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic pulse_restart(input int len);
    #1 restart = 1'b1;
    repeat (len) @(posedge clk);
    #1 restart = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired act=running exp=finished");
    report();
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R8 R11: full run after reset, past both ready points
    repeat (110) @(posedge clk);
    // R10: restarts at random points of the sequence
    for (int i = 0; i < 8; i++) begin
      int n;
      n = 1 + int'($urandom % 110);
      repeat (n) @(posedge clk);
      pulse_restart(1);
    end
    // R10 corner: restart held for two edges, then one right at cke rise of u1
    repeat (30) @(posedge clk);
    pulse_restart(2);
    repeat (B_ST + 1) @(posedge clk);
    pulse_restart(1);
    // R1-R9 repeat after restart: complete run to ready
    repeat (120) @(posedge clk);
    #1;
    report();
  end

endmodule